// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block couples two 8-bit ports, A and B, either of which can receive or send. A shared active-low enable and a direction control choose which port, if any, the block drives. For each direction there is a storage register, and a per-direction source select decides what the driven port carries. It can carry the live level of the opposite port or the value last captured from that port.

Each port is split into an input vector, an output vector and one drive-enable bit, so no tri-state logic is needed inside. The environment resolves the pin: it drives the input vector only while the drive-enable is low. The data paths from the controls and the port inputs to the outputs are purely combinational.

The two capture controls are level inputs sampled on the system clock. A capture happens on the clock edge where a capture input is seen high after having been seen low. The enable and the direction control have no effect on captures. While a port is being driven, its register takes the level the block itself puts on that port. The storage registers have no reset. Reset only clears the memory of the previous capture-input levels.

Top module: `xcvr_reg_bidir`

## Requirements
- R1: While `oe_n` is 1, both `a_oe` and `b_oe` are 0.
- R2: While `oe_n` is 0, `dir`=1 gives `b_oe`=1 and `a_oe`=0, and `dir`=0 gives `a_oe`=1 and `b_oe`=0. The two drive-enables are never both 1.
- R3: With `sel_ab`=0 (live), `b_out` equals `a_in` in the same cycle, with no clock edge involved.
- R4: With `sel_ab`=1 (stored), `b_out` equals the A storage register.
- R5: With `sel_ba`=0, `a_out` equals `b_in` in the same cycle. With `sel_ba`=1, `a_out` equals the B storage register. A change of `sel_ba` takes effect with no clock edge.
- R6: A storage register loads its port level on a clock edge where its capture input is 1 and was 0 at the previous edge. A capture input held at 1 loads the register only once.
- R7: Captures take place whatever the values of `oe_n` and `dir`, including while both ports are undriven.
- R8: When a port is driven by the block, its register captures the driven value (`a_out` or `b_out`) and not the port input vector.
- R9: While `rst` is 1 no capture occurs. After reset the previous capture level counts as 0, so a capture input already at 1 on the first edge after reset loads its register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset of the capture-edge detectors |
| oe_n | input | 1 | Active-low shared output enable |
| dir | input | 1 | 1: A receives, B driven; 0: B receives, A driven |
| cap_ab | input | 1 | Capture request for the A storage register |
| cap_ba | input | 1 | Capture request for the B storage register |
| sel_ab | input | 1 | Source for B: 0 live A, 1 stored A |
| sel_ba | input | 1 | Source for A: 0 live B, 1 stored B |
| a_in | input | 8 | Level seen on port A when not driven |
| a_out | output | 8 | Value the block puts on port A |
| a_oe | output | 1 | Port A drive enable |
| b_in | input | 8 | Level seen on port B when not driven |
| b_out | output | 8 | Value the block puts on port B |
| b_oe | output | 1 | Port B drive enable |

## Verification
The hardest case to reach is a capture into the register of a port that the block is itself driving. Here the register must take the block's own output, and the output may itself come from the other register. The bench drives a deliberately different pattern on the input vector of a driven port, so any use of it shows up. It pairs the opposite port's sources and capture strobes in directed sequences before random runs. A second hard case is a capture request held high across the end of reset. A directed sequence holds a strobe through reset and checks both that nothing loads during reset and that exactly one load follows.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;

  typedef struct packed {
    logic drive_a;
    logic drive_b;
  } xcvr_drive_t;

endpackage

// File: rtl/xcvr_drive_ctl.sv
module xcvr_drive_ctl
  import xcvr_pkg::*;
(
  input  logic        oe_n,
  input  logic        dir,
  output xcvr_drive_t drive
);

  always_comb begin
    drive.drive_a = 1'b0;
    drive.drive_b = 1'b0;
    if (!oe_n) begin
      if (dir) drive.drive_b = 1'b1;
      else     drive.drive_a = 1'b1;
    end
  end

endmodule

// File: rtl/xcvr_src_mux.sv
module xcvr_src_mux
  import xcvr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  src_sel_e         sel,
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] stored,
  output logic [WIDTH-1:0] y
);

  always_comb begin
    unique case (sel)
      SRC_STORED: y = stored;
      default:    y = live;
    endcase
  end

endmodule

// File: rtl/xcvr_capture.sv
module xcvr_capture #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             strobe,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic strobe_q;
  logic rise;

  assign rise = strobe && !strobe_q && !rst;

  always_ff @(posedge clk) begin
    if (rst) strobe_q <= 1'b0;
    else     strobe_q <= strobe;
  end

  always_ff @(posedge clk) begin
    if (rise) q <= d;
  end

  p_load_r6: assert property (@(posedge clk) disable iff (rst)
    (strobe && !strobe_q) |=> (q == $past(d)))
    else $error("p_load_r6: register did not take its input on a capture edge");

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (strobe_q || !strobe) |=> $stable(q))
    else $error("p_hold_r6: register changed without a capture edge");

  p_nocap_rst_r9: assert property (@(posedge clk)
    rst |=> $stable(q))
    else $error("p_nocap_rst_r9: register changed during reset");

endmodule

// File: rtl/xcvr_reg_bidir.sv
module xcvr_reg_bidir
  import xcvr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             oe_n,
  input  logic             dir,
  input  logic             cap_ab,
  input  logic             cap_ba,
  input  logic             sel_ab,
  input  logic             sel_ba,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);

  xcvr_drive_t      drive;
  logic [WIDTH-1:0] store_a;
  logic [WIDTH-1:0] store_b;
  logic [WIDTH-1:0] level_a;
  logic [WIDTH-1:0] level_b;

  xcvr_drive_ctl u_drive (
    .oe_n  (oe_n),
    .dir   (dir),
    .drive (drive)
  );

  assign a_oe = drive.drive_a;
  assign b_oe = drive.drive_b;

  xcvr_src_mux #(.WIDTH(WIDTH)) u_mux_to_b (
    .sel    (src_sel_e'(sel_ab)),
    .live   (a_in),
    .stored (store_a),
    .y      (b_out)
  );

  xcvr_src_mux #(.WIDTH(WIDTH)) u_mux_to_a (
    .sel    (src_sel_e'(sel_ba)),
    .live   (b_in),
    .stored (store_b),
    .y      (a_out)
  );

  // Resolved pin level: the block's own value while it drives the port.
  assign level_a = a_oe ? a_out : a_in;
  assign level_b = b_oe ? b_out : b_in;

  xcvr_capture #(.WIDTH(WIDTH)) u_cap_a (
    .clk    (clk),
    .rst    (rst),
    .strobe (cap_ab),
    .d      (level_a),
    .q      (store_a)
  );

  xcvr_capture #(.WIDTH(WIDTH)) u_cap_b (
    .clk    (clk),
    .rst    (rst),
    .strobe (cap_ba),
    .d      (level_b),
    .q      (store_b)
  );

  p_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
    !(a_oe && b_oe))
    else $error("p_exclusive_r2: both ports driven");

  p_off_r1: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> (!a_oe && !b_oe))
    else $error("p_off_r1: port driven while disabled");

  p_live_r3: assert property (@(posedge clk) disable iff (rst)
    !sel_ab |-> (b_out == a_in))
    else $error("p_live_r3: live path to B broken");

  p_resolved_r8: assert property (@(posedge clk) disable iff (rst)
    (a_oe && cap_ab && !$past(cap_ab)) |=> (store_a == $past(a_out)))
    else $error("p_resolved_r8: driven level not captured on A");

endmodule

// File: tb/xcvr_reg_bidir_tb_top.sv
module xcvr_reg_bidir_tb_top;

  logic       clk = 1'b0;
  logic       rst, oe_n, dir, cap_ab, cap_ba, sel_ab, sel_ba;
  logic [7:0] a_in, b_in, a_out, b_out;
  logic       a_oe, b_oe;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [7:0] m_a, m_b;
  bit va = 0, vb = 0;
  bit prev_ab = 0, prev_ba = 0;

  always #5 clk = ~clk;

  xcvr_reg_bidir #(.WIDTH(8)) dut_i (
    .clk(clk), .rst(rst), .oe_n(oe_n), .dir(dir),
    .cap_ab(cap_ab), .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit exp_aoe(); return !oe_n && !dir; endfunction
  function automatic bit exp_boe(); return !oe_n && dir;  endfunction

  task automatic check_comb();
    bit ea, eb;
    ea = exp_aoe();
    eb = exp_boe();
    chk(a_oe == ea && b_oe == eb, oe_n ? "R1" : "R2",
        {14'd0, a_oe, b_oe}, {14'd0, ea, eb});
    if (!sel_ab)  chk(b_out == a_in, "R3", {8'd0, b_out}, {8'd0, a_in});
    else if (va)  chk(b_out == m_a,  "R4", {8'd0, b_out}, {8'd0, m_a});
    if (!sel_ba)  chk(a_out == b_in, "R5", {8'd0, a_out}, {8'd0, b_in});
    else if (vb)  chk(a_out == m_b,  "R5", {8'd0, a_out}, {8'd0, m_b});
  endtask

  // Model of what the next clock edge does to the storage registers.
  task automatic model_edge();
    bit         rise_a, rise_b, ok_a, ok_b;
    logic [7:0] lvl_a, lvl_b;
    ok_a  = 1; ok_b = 1;
    lvl_a = a_in; lvl_b = b_in;
    if (exp_aoe()) begin
      lvl_a = sel_ba ? m_b : b_in;
      ok_a  = !sel_ba || vb;
    end
    if (exp_boe()) begin
      lvl_b = sel_ab ? m_a : a_in;
      ok_b  = !sel_ab || va;
    end
    rise_a = !rst && cap_ab && !prev_ab;
    rise_b = !rst && cap_ba && !prev_ba;
    if (rise_a) begin m_a = lvl_a; va = ok_a; end
    if (rise_b) begin m_b = lvl_b; vb = ok_b; end
    prev_ab = rst ? 1'b0 : cap_ab;
    prev_ba = rst ? 1'b0 : cap_ba;
  endtask

  task automatic step();
    #1;
    check_comb();
    model_edge();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1; oe_n = 1; dir = 0; cap_ab = 0; cap_ba = 0;
    sel_ab = 0; sel_ba = 0; a_in = 8'h00; b_in = 8'h00;
    @(negedge clk);
    for (int i = 0; i < 3; i++) step();
    #1;
    chk(a_oe == 0 && b_oe == 0, "R1", {14'd0, a_oe, b_oe}, 16'd0);
    rst = 0;
    step();

    // R7: capture both registers while disabled
    a_in = 8'h3C; b_in = 8'hC3; cap_ab = 1; cap_ba = 1;
    step();
    cap_ab = 0; cap_ba = 0;
    step();
    oe_n = 0; dir = 1; sel_ab = 1; a_in = 8'h00; #1;
    chk(b_out == 8'h3C, "R7", {8'd0, b_out}, 16'h003C);
    chk(b_oe == 1 && a_oe == 0, "R2", {14'd0, a_oe, b_oe}, 16'h0001);
    dir = 0; sel_ba = 1; b_in = 8'h00; #1;
    chk(a_out == 8'hC3, "R5", {8'd0, a_out}, 16'h00C3);
    sel_ba = 0; b_in = 8'h99; #1;
    chk(a_out == 8'h99, "R5", {8'd0, a_out}, 16'h0099);
    step();

    // R6: held strobe loads only once
    oe_n = 1; sel_ab = 1; a_in = 8'h51; cap_ab = 1;
    step();
    a_in = 8'hA2; step();
    a_in = 8'hE7; step();
    #1;
    chk(b_out == 8'h51, "R6", {8'd0, b_out}, 16'h0051);
    cap_ab = 0; step();

    // R8: A driven from live B; A input vector carries other data
    oe_n = 0; dir = 0; sel_ba = 0; b_in = 8'h5A; a_in = 8'hFF; cap_ab = 1;
    step();
    cap_ab = 0; dir = 1; sel_ab = 1; #1;
    chk(b_out == 8'h5A, "R8", {8'd0, b_out}, 16'h005A);
    step();
    // R8: B driven from stored A, capture into B
    b_in = 8'h0F; cap_ba = 1; step();
    cap_ba = 0; oe_n = 1; sel_ba = 1; #1;
    chk(a_out == 8'h5A, "R8", {8'd0, a_out}, 16'h005A);
    step();

    // R9: no capture during reset; held strobe captures right after
    sel_ab = 1; rst = 1; cap_ab = 1; a_in = 8'h11;
    step(); step();
    #1;
    chk(b_out == 8'h5A, "R9", {8'd0, b_out}, 16'h005A);
    a_in = 8'h77; rst = 0;
    step();
    #1;
    chk(b_out == 8'h77, "R9", {8'd0, b_out}, 16'h0077);
    cap_ab = 0; step();

    // Random phase
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 600; i++) begin
      oe_n   = $urandom_range(0, 3) == 0;
      dir    = $urandom_range(0, 1);
      cap_ab = $urandom_range(0, 1);
      cap_ba = $urandom_range(0, 1);
      sel_ab = $urandom_range(0, 1);
      sel_ba = $urandom_range(0, 1);
      a_in   = 8'($urandom);
      b_in   = 8'($urandom);
      step();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule